// File: doc/BRIEF.md
# AHB-Lite to APB Bridge

This block lets a single AHB-Lite master reach up to four low-bandwidth peripherals on an APB segment. On its upstream side it behaves as an AHB-Lite slave. Downstream it is the only APB master. It captures each accepted AHB address and holds it for the whole APB transfer. Address bits [15:12] pick one peripheral select, and each transfer runs through the APB idle, setup and enable phases. Write data travels down and read data is returned in the same cycle it appears. The upstream ready output is held low while an APB transfer still blocks the master.

AHB is pipelined and APB is not, so the bridge keeps two address slots. The current slot drives the APB segment. The pending slot captures the next AHB address while the current transfer finishes. Writes finish on AHB with no wait state, because the write data is captured during the AHB data phase and the APB write follows on its own. A read must wait for its own APB enable phase. Every transfer completes normally. An unmapped address raises no select and returns zero.

The controller has four states. `BR_IDLE` means no APB transfer is running. `BR_WDATA` is one cycle in which the write data of a newly accepted write is captured. `BR_SETUP` drives a select with the enable strobe low. `BR_ENABLE` raises the enable strobe. The transitions are:
- `BR_IDLE`: an accepted write goes to `BR_WDATA` and an accepted read goes to `BR_SETUP`.
- `BR_WDATA` always goes to `BR_SETUP`.
- `BR_SETUP` always goes to `BR_ENABLE`.
- `BR_ENABLE` goes to `BR_SETUP` when the pending slot is full or when a read is accepted. It goes to `BR_WDATA` when a write is accepted with the pending slot empty. Otherwise it goes to `BR_IDLE`.

Top module: `ahb_apb_bridge`

## Requirements
- R1: While `hresetn` is low, `psel` is all zero, `penable` is low and `hreadyout` is high. A reset during a transfer abandons it, and no APB transfer follows.
- R2: Each APB transfer holds a select for exactly one cycle with `penable` low and then exactly one cycle with `penable` high. The select does not change between those two cycles, and `penable` is never high without a select.
- R3: `paddr`, `pwrite` and `pwdata` are unchanged from the setup cycle to the enable cycle of a transfer.
- R4: When address field [15:12] of the transfer holds a value k below 4, only `psel[k]` is raised. At most one select bit is ever high.
- R5: When field [15:12] is 4 or above, no select and no `penable` is raised. A read returns zero after one wait state, and a write completes with no wait state and has no effect.
- R6: A single read from an idle bridge costs exactly one AHB wait state. Its `hrdata` equals the selected peripheral's `prdata` in the enable cycle.
- R7: A single write from an idle bridge completes with zero AHB wait states. The `hwdata` of its data phase appears on `pwdata`.
- R8: Back-to-back transfers are accepted through the pending slot. Four consecutive writes cost three wait states in total, and four consecutive reads cost four.
- R9: APB transfers occur in the order the AHB master issued them, one per accepted mapped transfer. After the last one the bridge returns to idle with no select.
- R10: A write immediately followed by a read costs three wait states in total. The read returns the data just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock for both bus sides |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Bridge selected on AHB |
| haddr | input | AW | AHB address |
| htrans | input | 2 | AHB transfer type; bit 1 set means a real transfer |
| hwrite | input | 1 | AHB direction, high for write |
| hwdata | input | DW | AHB write data (data phase) |
| hreadyout | output | 1 | Low while the current AHB data phase is stalled |
| hrdata | output | DW | AHB read data |
| paddr | output | AW | APB address, held from the current slot |
| psel | output | NSLV | One-hot peripheral select |
| penable | output | 1 | APB enable strobe |
| pwrite | output | 1 | APB direction |
| pwdata | output | DW | APB write data |
| prdata | input | NSLV*DW | Read data of each peripheral, peripheral k in slice k |

## Verification
Single reads and single writes issued to an idle bridge separate the one-wait read path from the zero-wait write path. Unbroken runs of four writes, of four reads, and a write followed straight by a read each fill the pending slot in a different way, and their total wait counts show whether the queueing works. Unmapped field values 4 and 5 test the decode boundary, which an aliasing decoder would get wrong. Randomly spaced mixed traffic, checked against a reference memory and an in-order list of expected APB transfers, catches reordering, lost or duplicated transfers and data corruption.

// File: rtl/apbr_pkg.sv
package apbr_pkg;
    // Controller states of the bridge
    typedef enum logic [1:0] {
        BR_IDLE   = 2'd0,
        BR_WDATA  = 2'd1,
        BR_SETUP  = 2'd2,
        BR_ENABLE = 2'd3
    } br_state_e;
endpackage

// File: rtl/apbr_slot.sv
// Address/direction holding register; used for both the current and the pending slot.
module apbr_slot #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] d_addr,
    input  logic          d_wr,
    output logic [AW-1:0] q_addr,
    output logic          q_wr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_wr   <= 1'b0;
        end else if (ld) begin
            q_addr <= d_addr;
            q_wr   <= d_wr;
        end
    end
endmodule

// File: rtl/apbr_decode.sv
// Turns the peripheral index field into a one-hot select; values past NSLV hit nothing.
module apbr_decode #(
    parameter int NSLV  = 4,
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] fld,
    output logic [NSLV-1:0]  onehot,
    output logic             hit
);
    localparam logic [31:0] NSLV_U = NSLV;

    assign hit = (32'(fld) < NSLV_U);

    for (genvar i = 0; i < NSLV; i++) begin : g_sel
        assign onehot[i] = (fld == SEL_W'(i));
    end
endmodule

// File: rtl/apbr_rdmux.sv
// AND-OR read data selector over the per-peripheral read buses.
module apbr_rdmux #(
    parameter int DW   = 32,
    parameter int NSLV = 4
) (
    input  logic [NSLV-1:0]    sel,
    input  logic [NSLV*DW-1:0] bus,
    output logic [DW-1:0]      q
);
    always_comb begin
        q = '0;
        for (int i = 0; i < NSLV; i++) begin
            if (sel[i]) q = q | bus[i*DW +: DW];
        end
    end
endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
    import apbr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int NSLV    = 4,
    parameter int SEL_LSB = 12,
    parameter int SEL_W   = 4
) (
    input  logic               hclk,
    input  logic               hresetn,
    input  logic               hsel,
    input  logic [AW-1:0]      haddr,
    input  logic [1:0]         htrans,
    input  logic               hwrite,
    input  logic [DW-1:0]      hwdata,
    output logic               hreadyout,
    output logic [DW-1:0]      hrdata,
    output logic [AW-1:0]      paddr,
    output logic [NSLV-1:0]    psel,
    output logic               penable,
    output logic               pwrite,
    output logic [DW-1:0]      pwdata,
    input  logic [NSLV*DW-1:0] prdata
);
    br_state_e state, state_nx;

    logic          accept;
    logic          ld_cur, ld_pend;
    logic [AW-1:0] cur_d_addr;
    logic          cur_d_wr;
    logic [AW-1:0] cur_addr, pend_addr;
    logic          cur_wr, pend_wr;
    logic          pend_v, pend_v_nx;
    logic          dp_act, dp_wr, wcap;
    logic [DW-1:0] wdata_q;
    logic [NSLV-1:0] sel_oh;
    logic          sel_hit;
    logic [DW-1:0] rd_mux;
    logic          unused_seq_bit;

    // SEQ and NONSEQ are handled alike; only bit 1 marks a real transfer
    assign unused_seq_bit = htrans[0];
    assign accept = hsel & htrans[1] & hreadyout;
    // write data phase finishing this cycle: capture the data
    assign wcap   = dp_act & dp_wr & hreadyout;

    apbr_slot #(.AW(AW)) u_cur (
        .clk(hclk), .rst_n(hresetn), .ld(ld_cur),
        .d_addr(cur_d_addr), .d_wr(cur_d_wr),
        .q_addr(cur_addr), .q_wr(cur_wr)
    );

    apbr_slot #(.AW(AW)) u_pend (
        .clk(hclk), .rst_n(hresetn), .ld(ld_pend),
        .d_addr(haddr), .d_wr(hwrite),
        .q_addr(pend_addr), .q_wr(pend_wr)
    );

    apbr_decode #(.NSLV(NSLV), .SEL_W(SEL_W)) u_dec (
        .fld(cur_addr[SEL_LSB +: SEL_W]),
        .onehot(sel_oh),
        .hit(sel_hit)
    );

    apbr_rdmux #(.DW(DW), .NSLV(NSLV)) u_rdmux (
        .sel(sel_oh),
        .bus(prdata),
        .q(rd_mux)
    );

    // Next state and slot loading
    always_comb begin
        state_nx   = state;
        ld_cur     = 1'b0;
        ld_pend    = 1'b0;
        pend_v_nx  = pend_v;
        cur_d_addr = haddr;
        cur_d_wr   = hwrite;
        unique case (state)
            BR_IDLE: begin
                ld_cur = accept;
                if (accept) state_nx = hwrite ? BR_WDATA : BR_SETUP;
            end
            BR_WDATA: begin
                ld_pend = accept;
                if (accept) pend_v_nx = 1'b1;
                state_nx = BR_SETUP;
            end
            BR_SETUP: begin
                ld_pend = accept;
                if (accept) pend_v_nx = 1'b1;
                state_nx = BR_ENABLE;
            end
            BR_ENABLE: begin
                if (pend_v) begin
                    ld_cur     = 1'b1;
                    cur_d_addr = pend_addr;
                    cur_d_wr   = pend_wr;
                    ld_pend    = accept;
                    pend_v_nx  = accept;
                    state_nx   = BR_SETUP;
                end else if (accept) begin
                    ld_cur   = 1'b1;
                    state_nx = hwrite ? BR_WDATA : BR_SETUP;
                end else begin
                    state_nx = BR_IDLE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) state <= BR_IDLE;
        else          state <= state_nx;
    end

    // Pending flag, AHB data-phase tracking and write data holding
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            pend_v  <= 1'b0;
            dp_act  <= 1'b0;
            dp_wr   <= 1'b0;
            wdata_q <= '0;
        end else begin
            pend_v <= pend_v_nx;
            if (hreadyout) begin
                dp_act <= accept;
                dp_wr  <= hwrite;
            end
            if (wcap) wdata_q <= hwdata;
        end
    end

    // Outputs
    always_comb begin
        hreadyout = 1'b1;
        psel      = '0;
        penable   = 1'b0;
        hrdata    = '0;
        unique case (state)
            BR_IDLE, BR_WDATA: hreadyout = 1'b1;
            BR_SETUP: begin
                // a read waits for its enable cycle; a queued transfer waits its turn
                hreadyout = cur_wr & ~pend_v;
                psel      = sel_oh;
            end
            BR_ENABLE: begin
                // only a queued read stays stalled across a write's enable cycle
                hreadyout = ~cur_wr | ~pend_v | pend_wr;
                psel      = sel_oh;
                penable   = sel_hit;
                if (!cur_wr) hrdata = rd_mux;
            end
        endcase
    end

    assign paddr  = cur_addr;
    assign pwrite = cur_wr;
    assign pwdata = wdata_q;
endmodule

// File: rtl/apbr_bridge_chk.sv
module apbr_bridge_chk #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int NSLV    = 4,
    parameter int SEL_LSB = 12,
    parameter int SEL_W   = 4
) (
    input logic            hclk,
    input logic            hresetn,
    input logic            hreadyout,
    input logic [AW-1:0]   paddr,
    input logic [NSLV-1:0] psel,
    input logic            penable,
    input logic            pwrite,
    input logic [DW-1:0]   pwdata
);
    localparam logic [31:0] NSLV_U = NSLV;

    logic [SEL_W-1:0] fld;
    logic [NSLV-1:0]  exp_oh;
    logic             unmapped;

    assign fld      = paddr[SEL_LSB +: SEL_W];
    assign unmapped = (32'(fld) >= NSLV_U);

    always_comb begin
        exp_oh = '0;
        for (int i = 0; i < NSLV; i++) begin
            if (32'(fld) == 32'(i)) exp_oh[i] = 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge hclk)
        !hresetn |-> (psel == '0 && !penable && hreadyout));

    assert_setup_then_enable_R2: assert property (@(posedge hclk) disable iff (!hresetn)
        (|psel && !penable) |=> (penable && psel == $past(psel)));

    assert_enable_single_R2: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |=> !penable);

    assert_enable_needs_sel_R2: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |-> (|psel));

    assert_ctrl_stable_R3: assert property (@(posedge hclk) disable iff (!hresetn)
        (|psel && !penable) |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

    assert_sel_onehot_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(psel));

    assert_sel_decode_R4: assert property (@(posedge hclk) disable iff (!hresetn)
        (|psel) |-> (psel == exp_oh));

    assert_unmapped_quiet_R5: assert property (@(posedge hclk) disable iff (!hresetn)
        unmapped |-> (psel == '0 && !penable));

    assert_read_setup_waits_R6: assert property (@(posedge hclk) disable iff (!hresetn)
        (|psel && !penable && !pwrite) |-> !hreadyout);

    assert_read_enable_ready_R6: assert property (@(posedge hclk) disable iff (!hresetn)
        (penable && !pwrite) |-> hreadyout);
endmodule

bind ahb_apb_bridge apbr_bridge_chk #(
    .AW(AW), .DW(DW), .NSLV(NSLV), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)
) u_chk (
    .hclk(hclk),
    .hresetn(hresetn),
    .hreadyout(hreadyout),
    .paddr(paddr),
    .psel(psel),
    .penable(penable),
    .pwrite(pwrite),
    .pwdata(pwdata)
);

// File: tb/ahb_apb_bridge_tb.sv
`timescale 1ns/1ps
module ahb_apb_bridge_tb;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int NSLV   = 4;
    localparam int NWORD  = 16;
    localparam int CLK_NS = 20;

    logic               hclk = 1'b0;
    logic               hresetn;
    logic               hsel;
    logic [AW-1:0]      haddr;
    logic [1:0]         htrans;
    logic               hwrite;
    logic [DW-1:0]      hwdata;
    logic               hreadyout;
    logic [DW-1:0]      hrdata;
    logic [AW-1:0]      paddr;
    logic [NSLV-1:0]    psel;
    logic               penable;
    logic               pwrite;
    logic [DW-1:0]      pwdata;
    logic [NSLV*DW-1:0] prdata;

    always #(CLK_NS/2) hclk = ~hclk;

    ahb_apb_bridge u_dut (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata),
        .hreadyout(hreadyout), .hrdata(hrdata), .paddr(paddr),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .pwdata(pwdata), .prdata(prdata)
    );

    // Peripheral models and reference memory
    logic [DW-1:0] smem [NSLV][NWORD];
    logic [DW-1:0] rmem [NSLV][NWORD];

    for (genvar g = 0; g < NSLV; g++) begin : g_prd
        assign prdata[g*DW +: DW] = smem[g][paddr[5:2]];
    end

    int n_chk  = 0;
    int n_fail = 0;

    // Transaction list for a run
    logic [31:0] t_addr [512];
    bit          t_wr   [512];
    logic [31:0] t_data [512];

    // Expected APB transfers in issue order
    logic [31:0] e_addr [2048];
    bit          e_wr   [2048];
    logic [31:0] e_data [2048];
    int e_w = 0;
    int e_r = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int f, input int w);
        return (32'(f) << 12) | (32'(w) << 2);
    endfunction

    function automatic int fld_of(input logic [31:0] a);
        return int'(a[15:12]);
    endfunction

    function automatic bit is_mapped(input logic [31:0] a);
        return fld_of(a) < NSLV;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (is_mapped(a)) return rmem[fld_of(a)][a[5:2]];
        return 32'h0;
    endfunction

    // APB monitor and peripheral write port (mid-cycle)
    always @(negedge hclk) begin
        int si;
        if (hresetn && penable) begin
            si = -1;
            for (int i = 0; i < NSLV; i++) if (psel[i]) si = i;
            if (e_r >= e_w) begin
                chk(1'b0, "R9", "unexpected APB transfer", paddr, 32'h0);
            end else begin
                chk(paddr == e_addr[e_r] && pwrite == e_wr[e_r], "R9",
                    "APB transfer order/address", paddr, e_addr[e_r]);
                chk(si == fld_of(paddr), "R4", "select index", 32'(si), 32'(fld_of(paddr)));
                if (pwrite)
                    chk(pwdata == e_data[e_r], "R7", "APB write data", pwdata, e_data[e_r]);
                e_r++;
            end
            if (pwrite && si >= 0) smem[si][paddr[5:2]] = pwdata;
        end
    end

    task automatic set_txn(input int i, input int f, input int w, input bit wr,
                           input logic [31:0] dat);
        t_addr[i] = mk_addr(f, w);
        t_wr[i]   = wr;
        t_data[i] = dat;
    endtask

    // Pipelined AHB master: returns the number of stalled data-phase cycles
    task automatic run_seq(input int n, input bit gaps, output int waits);
        int a = 0;
        int d = -1;
        bit a_on;
        waits = 0;
        a_on = gaps ? ($urandom % 3 != 0) : 1'b1;
        while (a < n || d >= 0) begin
            @(negedge hclk);
            if (a < n && a_on) begin
                hsel = 1'b1; htrans = 2'b10; haddr = t_addr[a]; hwrite = t_wr[a];
            end else begin
                hsel = 1'b0; htrans = 2'b00; haddr = '0; hwrite = 1'b0;
            end
            hwdata = (d >= 0 && t_wr[d]) ? t_data[d] : $urandom;
            #1;
            if (!hreadyout) begin
                waits++;
            end else begin
                if (d >= 0) begin
                    if (t_wr[d]) begin
                        if (is_mapped(t_addr[d])) rmem[fld_of(t_addr[d])][t_addr[d][5:2]] = t_data[d];
                    end else begin
                        chk(hrdata == exp_read(t_addr[d]), is_mapped(t_addr[d]) ? "R6" : "R5",
                            "read data", hrdata, exp_read(t_addr[d]));
                    end
                end
                if (a < n && a_on) begin
                    d = a;
                    if (is_mapped(t_addr[a])) begin
                        e_addr[e_w] = t_addr[a];
                        e_wr[e_w]   = t_wr[a];
                        e_data[e_w] = t_data[a];
                        e_w++;
                    end
                    a++;
                end else begin
                    d = -1;
                end
                a_on = gaps ? ($urandom % 3 != 0) : 1'b1;
            end
        end
        hsel = 1'b0; htrans = 2'b00;
    endtask

    task automatic drain();
        repeat (8) @(negedge hclk);
    endtask

    initial begin
        repeat (200000) @(posedge hclk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd24681357);
        for (int s = 0; s < NSLV; s++)
            for (int k = 0; k < NWORD; k++) begin
                smem[s][k] = 32'hC0DE_0000 | (32'(s) << 8) | 32'(k);
                rmem[s][k] = smem[s][k];
            end
        hresetn = 1'b0; hsel = 1'b0; haddr = '0; htrans = 2'b00;
        hwrite = 1'b0; hwdata = '0;

        repeat (3) @(negedge hclk);
        chk(psel == '0 && !penable && hreadyout, "R1", "outputs during reset",
            {psel, penable, hreadyout}, 32'h1);
        hresetn = 1'b1;
        @(negedge hclk);

        // Single read
        set_txn(0, 2, 3, 1'b0, 32'h0);
        run_seq(1, 1'b0, w);
        chk(w == 1, "R6", "single read wait states", 32'(w), 32'd1);
        drain();
        chk(psel == '0 && !penable, "R9", "idle after last transfer", {psel, penable}, 32'h0);

        // Single write, then read it back
        set_txn(0, 1, 5, 1'b1, 32'h1234_5678);
        run_seq(1, 1'b0, w);
        chk(w == 0, "R7", "single write wait states", 32'(w), 32'd0);
        drain();
        set_txn(0, 1, 5, 1'b0, 32'h0);
        run_seq(1, 1'b0, w);
        drain();

        // Burst of writes to every peripheral
        for (int i = 0; i < 4; i++) set_txn(i, i, 9, 1'b1, 32'hA5A5_0000 + 32'(i));
        run_seq(4, 1'b0, w);
        chk(w == 3, "R8", "four back-to-back writes wait states", 32'(w), 32'd3);
        drain();

        // Burst of reads of the same words
        for (int i = 0; i < 4; i++) set_txn(i, i, 9, 1'b0, 32'h0);
        run_seq(4, 1'b0, w);
        chk(w == 4, "R8", "four back-to-back reads wait states", 32'(w), 32'd4);
        drain();

        // Write immediately followed by read of the same word
        set_txn(0, 2, 7, 1'b1, 32'h0BAD_F00D);
        set_txn(1, 2, 7, 1'b0, 32'h0);
        run_seq(2, 1'b0, w);
        chk(w == 3, "R10", "write then read wait states", 32'(w), 32'd3);
        drain();

        // Unmapped accesses
        set_txn(0, 5, 1, 1'b0, 32'h0);
        run_seq(1, 1'b0, w);
        chk(w == 1, "R5", "unmapped read wait states", 32'(w), 32'd1);
        set_txn(0, 4, 2, 1'b1, 32'hDEAD_BEEF);
        run_seq(1, 1'b0, w);
        chk(w == 0, "R5", "unmapped write wait states", 32'(w), 32'd0);
        drain();
        chk(e_r == e_w, "R5", "no APB transfer for unmapped", 32'(e_r), 32'(e_w));
        for (int s = 0; s < NSLV; s++) begin
            set_txn(s, s, 2, 1'b0, 32'h0);
        end
        run_seq(NSLV, 1'b0, w);
        drain();

        // Random mixed traffic with gaps
        for (int i = 0; i < 300; i++)
            set_txn(i, $urandom % 6, $urandom % NWORD, 1'($urandom % 2), $urandom);
        run_seq(300, 1'b1, w);
        drain();
        chk(e_r == e_w, "R9", "all issued transfers reached APB", 32'(e_r), 32'(e_w));

        // Reset during a transfer
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'b10; haddr = mk_addr(1, 1); hwrite = 1'b1;
        @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
        hresetn = 1'b0;
        #1;
        chk(psel == '0 && !penable && hreadyout, "R1", "outputs after reset mid-transfer",
            {psel, penable, hreadyout}, 32'h1);
        @(negedge hclk);
        hresetn = 1'b1;
        drain();
        chk(e_r == e_w, "R1", "abandoned transfer not issued", 32'(e_r), 32'(e_w));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule